// File: doc/BRIEF.md
# I2C Serial EEPROM Slave with Page Write

This block is an I2C slave that sits in front of a byte-wide on-chip memory and answers the bus the way a serial EEPROM does. Both bus lines arrive as plain inputs. The block pulls a line low by raising the matching output-enable, and the pad ring turns that into an open-drain driver. Both lines are brought into the system clock domain through a short synchroniser chain. Start and stop conditions and the SCL edges are then recovered from the synchronised copies.

A master addresses the slave with a control byte, then sends a two-byte word address and optional data. Write data is collected in a one-page buffer and reaches the memory only after the stop condition. A busy window follows, during which the slave ignores its own control byte. Reads return bytes from an internal address pointer, and the slave holds SCL low briefly before each byte it sends so the memory can be read. `ADDR_W` sets the capacity: 15 gives the full 32768 bytes, and the default of 12 keeps the elaborated array small.

Top module: `eep_slave`

## Requirements
- R1: After reset both output-enables are low (neither line is pulled) and the address pointer is zero.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start always begins a new control byte, which allows a repeated start in the middle of a transfer.
- R3: The control byte is sent MSB first as 1010, then `chip_sel[2]..chip_sel[0]`, then R/W (1 = read). On any mismatch SDA stays released in the ninth clock, so there is no acknowledge.
- R4: After an accepted control byte, the slave acknowledges by pulling SDA low in the ninth clock after each byte the master writes. These are the address high byte (its low `ADDR_W-8` bits are used), the address low byte, and each data byte.
- R5: During a write, only the low 6 pointer bits advance. Bytes beyond the end of a 64-byte page wrap to its first location, and a later byte to the same location replaces the earlier one.
- R6: Locations of the page that a write does not touch keep their previous contents.
- R7: Written data reaches the memory only after the stop condition. A read before that stop returns the old contents. For `BUSY_CYC` system cycles after that stop, control bytes are not acknowledged.
- R8: A random read consists of a write control byte, two address bytes, a repeated start and a read control byte. It returns the byte at that address, MSB first.
- R9: A sequential read advances the pointer through all `ADDR_W` bits and rolls over from the last location to zero. A master not-acknowledge ends the read.
- R10: A current-address read returns the byte one past the last byte read.
- R11: Before each byte it returns, the slave holds SCL low for about `STRETCH_CYC` system cycles. It starts doing so only while SCL is already low.
- R12: The bus SDA changes while SCL is high only when the master makes a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel | input | 3 | Strap value matched against the control byte |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge or data 0) |

## Verification
The bench is a bit-level bus master, and it holds its own model of the memory contents. Control bytes with a wrong type nibble and a wrong chip select tell address matching apart from plain acknowledging. A partial page write that crosses the page end, followed by a 66-byte write, exposes the in-page wrap and overwrite, and it shows whether the untouched bytes survive. A read issued before the stop that closes a pending write, and a control byte sent straight after a stop, separate the deferred commit from a write-through design and check the busy window. Sequential reads across the top address and current-address reads check how the pointer advances. A per-clock bus monitor checks SDA against SCL, and it records whether the master ever had to wait on a stretched clock.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_RX, S_RX_ACK, S_TX_LOAD, S_TX, S_TX_ACK
    } state_e;

    typedef enum logic [1:0] {
        P_CTRL, P_AHI, P_ALO, P_DATA
    } phase_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh_q, sda_sh_q;
    logic              scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q <= '1;
            sda_sh_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_sh_q <= {scl_sh_q[STAGES-2:0], scl_i};
            sda_sh_q <= {sda_sh_q[STAGES-2:0], sda_i};
            scl_p_q  <= scl_sh_q[STAGES-1];
            sda_p_q  <= sda_sh_q[STAGES-1];
        end
    end

    always_comb begin
        scl_s     = scl_sh_q[STAGES-1];
        sda_s     = sda_sh_q[STAGES-1];
        scl_rise  = scl_s & ~scl_p_q;
        scl_fall  = ~scl_s & scl_p_q;
        start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
        stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;
    end
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cell_q[waddr] <= wdata;
        rdata <= cell_q[raddr];
    end
endmodule

// File: rtl/eep_pagebuf.sv
module eep_pagebuf #(
    parameter int PAGE_AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               we,
    input  logic [PAGE_AW-1:0] woff,
    input  logic [7:0]         wdata,
    input  logic [PAGE_AW-1:0] roff,
    output logic [7:0]         rdata,
    output logic               rvalid,
    output logic               any
);
    localparam int PAGE_N = 1 << PAGE_AW;

    logic [7:0]        byte_q [PAGE_N];
    logic [PAGE_N-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (we) byte_q[woff] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   valid_q <= '0;
        else if (clr) valid_q <= '0;
        else if (we)  valid_q[woff] <= 1'b1;
    end

    always_comb begin
        rdata  = byte_q[roff];
        rvalid = valid_q[roff];
        any    = |valid_q;
    end

    // R6: a captured byte is marked for commit; others stay untouched
    a_r6_marked: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) |=> valid_q[$past(woff)]);
endmodule

// File: rtl/eep_slave.sv
module eep_slave
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PAGE_AW     = 6,
    parameter int BUSY_CYC    = 1000,
    parameter int STRETCH_CYC = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] chip_sel,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe
);
    localparam int PAGE_N   = 1 << PAGE_AW;
    localparam int BUSY_TOT = (BUSY_CYC < PAGE_N) ? PAGE_N : BUSY_CYC;
    localparam int BUSY_W   = $clog2(BUSY_TOT + 1);
    localparam int STR_W    = $clog2(STRETCH_CYC + 2);
    localparam int PG_W     = ADDR_W - PAGE_AW;

    typedef struct packed {
        state_e              st;
        phase_e              ph;
        logic [3:0]          cnt;
        logic [7:0]          sh;
        logic                rw;
        logic                mnack;
        logic [ADDR_W-1:0]   ptr;
        logic                sda_oe;
        logic                scl_oe;
        logic [STR_W-1:0]    str;
        logic [BUSY_W-1:0]   busy;
        logic [PAGE_AW:0]    cidx;
        logic [PG_W-1:0]     cpage;
    } regs_t;

    regs_t q, d;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic pb_we, pb_clr, pb_rvalid, pb_any, mem_we;
    logic [7:0] pb_rdata, mem_rdata;

    eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk, .rst_n, .scl_i, .sda_i, .scl_s, .sda_s,
        .scl_rise, .scl_fall, .start_det, .stop_det
    );

    eep_pagebuf #(.PAGE_AW(PAGE_AW)) u_pagebuf (
        .clk, .rst_n, .clr(pb_clr), .we(pb_we),
        .woff(q.ptr[PAGE_AW-1:0]), .wdata(q.sh),
        .roff(q.cidx[PAGE_AW-1:0]), .rdata(pb_rdata),
        .rvalid(pb_rvalid), .any(pb_any)
    );

    eep_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk, .we(mem_we), .waddr({q.cpage, q.cidx[PAGE_AW-1:0]}),
        .wdata(pb_rdata), .raddr(q.ptr), .rdata(mem_rdata)
    );

    always_comb begin
        mem_we = (q.busy != '0) && !q.cidx[PAGE_AW] && pb_rvalid;
        pb_clr = (q.busy == BUSY_W'(1));
    end

    always_comb begin
        d     = q;
        pb_we = 1'b0;
        if (q.busy != '0) begin
            d.busy = q.busy - 1'b1;
            if (!q.cidx[PAGE_AW]) d.cidx = q.cidx + 1'b1;
        end
        if (start_det) begin
            d.st     = S_RX;
            d.ph     = P_CTRL;
            d.cnt    = '0;
            d.sda_oe = 1'b0;
            d.scl_oe = 1'b0;
        end else if (stop_det) begin
            d.st     = S_IDLE;
            d.sda_oe = 1'b0;
            d.scl_oe = 1'b0;
            if (pb_any && q.busy == '0) begin
                d.busy = BUSY_W'(BUSY_TOT);
                d.cidx = '0;
            end
        end else begin
            case (q.st)
                S_RX: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt    = '0;
                        d.st     = S_RX_ACK;
                        d.sda_oe = 1'b1;
                        case (q.ph)
                            P_CTRL: begin
                                if (q.sh[7:1] == {DEV_TYPE, chip_sel} && q.busy == '0) begin
                                    d.rw = q.sh[0];
                                end else begin
                                    d.st     = S_IDLE;
                                    d.sda_oe = 1'b0;
                                end
                            end
                            P_AHI:  d.ptr[ADDR_W-1:8] = q.sh[ADDR_W-9:0];
                            P_ALO:  d.ptr[7:0] = q.sh;
                            default: begin
                                pb_we   = 1'b1;
                                d.cpage = q.ptr[ADDR_W-1:PAGE_AW];
                                d.ptr[PAGE_AW-1:0] = q.ptr[PAGE_AW-1:0] + 1'b1;
                            end
                        endcase
                    end
                end
                S_RX_ACK: begin
                    if (scl_fall) begin
                        d.sda_oe = 1'b0;
                        if (q.ph == P_CTRL && q.rw) begin
                            d.st     = S_TX_LOAD;
                            d.scl_oe = 1'b1;
                            d.str    = STR_W'(STRETCH_CYC);
                        end else begin
                            d.st = S_RX;
                            case (q.ph)
                                P_CTRL:  d.ph = P_AHI;
                                P_AHI:   d.ph = P_ALO;
                                default: d.ph = P_DATA;
                            endcase
                        end
                    end
                end
                S_TX_LOAD: begin
                    if (q.str != '0) begin
                        d.str = q.str - 1'b1;
                    end else begin
                        d.sh     = mem_rdata;
                        d.sda_oe = ~mem_rdata[7];
                        d.scl_oe = 1'b0;
                        d.ptr    = q.ptr + 1'b1;
                        d.cnt    = '0;
                        d.st     = S_TX;
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.sda_oe = 1'b0;
                            d.st     = S_TX_ACK;
                        end else begin
                            d.sh     = {q.sh[6:0], 1'b0};
                            d.sda_oe = ~q.sh[6];
                            d.cnt    = q.cnt + 4'd1;
                        end
                    end
                end
                S_TX_ACK: begin
                    if (scl_rise) begin
                        d.mnack = sda_s;
                    end else if (scl_fall) begin
                        if (q.mnack) begin
                            d.st = S_IDLE;
                        end else begin
                            d.st     = S_TX_LOAD;
                            d.scl_oe = 1'b1;
                            d.str    = STR_W'(STRETCH_CYC);
                        end
                    end
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
            q.ph <= P_CTRL;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        scl_oe = q.scl_oe;
        sda_oe = q.sda_oe;
    end

    // R12: the slave never moves SDA while SCL stays high
    a_r12_sda_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(q.sda_oe));

    // R11: stretching begins only on a clock that is already low
    a_r11_stretch_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.scl_oe) |-> !scl_s);

    // R7: no control-byte acknowledge inside the busy window
    a_r7_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy > BUSY_W'(1)) |=> !(q.st == S_RX_ACK && q.ph == P_CTRL));

    // R5: a captured data byte never moves the pointer to another page
    a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        pb_we |=> (q.ptr[ADDR_W-1:PAGE_AW] == $past(q.ptr[ADDR_W-1:PAGE_AW])));
endmodule

// File: tb/eep_slave_bench.sv
module eep_slave_bench;
    localparam int AW   = 12;
    localparam int Q    = 6;
    localparam int STR  = 20;
    localparam int BUSY = 1000;
    localparam logic [2:0] CS = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_oe, sda_oe, scl_bus, sda_bus;
    logic prev_scl = 1'b1, prev_sda = 1'b1;
    logic allow_ss = 1'b0;
    int   nvec = 0, nerr = 0, stretch_seen = 0;
    logic [7:0] ref_mem [0:(1<<AW)-1];

    always #2 clk = ~clk;

    assign scl_bus = scl_m & ~scl_oe;
    assign sda_bus = sda_m & ~sda_oe;

    eep_slave #(.ADDR_W(AW), .BUSY_CYC(BUSY), .STRETCH_CYC(STR)) u_eep_slave (
        .clk, .rst_n, .chip_sel(CS), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe, .sda_oe
    );

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R12 per-clock bus reference: SDA steady while SCL high outside start/stop
    always @(negedge clk) begin
        if (rst_n) begin
            nvec++;
            if (!allow_ss && scl_bus && prev_scl && sda_bus !== prev_sda) begin
                nerr++;
                $display("FAIL R12 actual=%0b expected=%0b", sda_bus, prev_sda);
            end
            if (scl_m && !scl_bus) stretch_seen++;
        end
        prev_scl <= scl_bus;
        prev_sda <= sda_bus;
    end

    task automatic wc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic scl_up();
        scl_m = 1'b1;
        wc(1);
        while (!scl_bus) wc(1);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wc(Q);
        scl_up(); wc(2*Q);
        scl_m = 1'b0; wc(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wc(Q);
        scl_up(); wc(Q);
        b = sda_bus; wc(Q);
        scl_m = 1'b0; wc(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output int ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        ack = (a == 1'b0) ? 1 : 0;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic nack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(nack);
    endtask

    task automatic start_c();
        sda_m = 1'b1; wc(Q);
        scl_up(); wc(Q);
        allow_ss = 1'b1; sda_m = 1'b0; wc(Q);
        allow_ss = 1'b0; scl_m = 1'b0; wc(Q);
    endtask

    task automatic stop_c();
        scl_m = 1'b0; sda_m = 1'b0; wc(Q);
        scl_up(); wc(Q);
        allow_ss = 1'b1; sda_m = 1'b1; wc(Q);
        allow_ss = 1'b0; wc(Q);
    endtask

    task automatic send_addr(input int addr);
        int ack;
        start_c();
        send_byte({4'b1010, CS, 1'b0}, ack); chk("R3 ctrl accepted", ack, 1);
        send_byte(8'((addr >> 8) & 'hFF), ack); chk("R4 addr hi ack", ack, 1);
        send_byte(8'(addr & 'hFF), ack);        chk("R4 addr lo ack", ack, 1);
    endtask

    task automatic wr_page(input int addr, input int n, input int seed);
        int ack;
        int pg;
        send_addr(addr);
        pg = addr & ~63;
        for (int i = 0; i < n; i++) begin
            send_byte(8'(seed + i), ack);
            chk("R4 data ack", ack, 1);
            ref_mem[pg + ((addr + i) & 63)] = 8'(seed + i);
        end
        stop_c();
        wc(BUSY + 50);
    endtask

    task automatic rd_cont(input int first, input int n, input string req);
        int ack;
        logic [7:0] v;
        start_c();
        send_byte({4'b1010, CS, 1'b1}, ack); chk("R2 repeated start read ctrl", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(v, (i == n - 1));
            chk(req, v, ref_mem[(first + i) % (1 << AW)]);
        end
        stop_c();
    endtask

    task automatic rd_seq(input int addr, input int n, input string req);
        send_addr(addr);
        rd_cont(addr, n, req);
    endtask

    initial begin
        int ack;
        logic [7:0] v;
        wc(5);
        chk("R1 scl_oe reset", scl_oe, 0);
        chk("R1 sda_oe reset", sda_oe, 0);
        rst_n = 1'b1;
        wc(10);
        chk("R1 released after reset", {scl_oe, sda_oe}, 0);

        // R3: wrong chip select, then wrong device type
        start_c();
        send_byte({4'b1010, 3'b010, 1'b0}, ack); chk("R3 cs mismatch nack", ack, 0);
        stop_c();
        start_c();
        send_byte({4'b1011, CS, 1'b0}, ack); chk("R3 type mismatch nack", ack, 0);
        stop_c();

        // R4/R7: byte write, then control during busy is refused
        send_addr('h010);
        send_byte(8'hA5, ack); chk("R4 data ack", ack, 1);
        ref_mem['h010] = 8'hA5;
        stop_c();
        start_c();
        send_byte({4'b1010, CS, 1'b0}, ack); chk("R7 busy nack", ack, 0);
        stop_c();
        wc(BUSY + 50);
        rd_seq('h010, 1, "R8 random read");

        // R5/R6: full page, then partial write wrapping at page end
        wr_page('h100, 64, 'h3C);
        wr_page('h13E, 3, 'hE0);
        rd_seq('h100, 64, "R5 R6 page wrap and keep");

        // R5: over-long page write overwrites from the page start
        wr_page('h200, 66, 'h80);
        rd_seq('h200, 64, "R5 overflow overwrite");

        // R10: current-address read after a one-byte random read
        rd_seq('h210, 1, "R8 random read");
        rd_cont('h211, 2, "R10 current address");

        // R9: rollover from the top location to zero
        wr_page((1 << AW) - 1, 1, 'h77);
        wr_page(0, 1, 'h11);
        rd_seq((1 << AW) - 1, 2, "R9 rollover");

        // R7: read before the stop sees old data; after the stop, new data
        wr_page('h020, 1, 'h12);
        send_addr('h020);
        send_byte(8'h99, ack); chk("R4 data ack", ack, 1);
        send_addr('h020);
        start_c();
        send_byte({4'b1010, CS, 1'b1}, ack); chk("R2 repeated start", ack, 1);
        recv_byte(v, 1'b1);
        chk("R7 no commit before stop", v, 'h12);
        stop_c();
        ref_mem['h020] = 8'h99;
        wc(BUSY + 50);
        rd_seq('h020, 1, "R7 commit after stop");

        chk("R11 master saw stretch", (stretch_seen > 0) ? 1 : 0, 1);

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule